// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block runs the transmit side of a network controller's buffer management. Software places a circular list of descriptors in a word-addressed descriptor memory. Each descriptor names one buffer and a status byte, and the engine walks the list in order. For every descriptor whose ownership flag is set, it reads the buffer pointer and length and offers them to the MAC over a valid/ready request channel. Several descriptors can be chained into one frame with start and end markers. Once the MAC reports how the frame went out, the engine writes the outcome back into the final descriptor and returns every consumed descriptor to software by clearing its ownership flag.

Software controls the engine with a level `run` input, a ring base address, a 3-bit ring size code and a one-cycle `tx_demand` pulse. When the engine finds a descriptor it does not own, it stops polling. A fixed group of fatal outcomes parks the engine with `tx_off` raised, and only a stop/start cycle of `run` releases it. A read fault on the descriptor memory produces a `mem_error` pulse and parks the engine in the same way.

Top module: `tx_ring_engine`

## Requirements
- R1: Descriptor k occupies words B+4k to B+4k+3, where B is `ring_base` with its two low bits forced to 0. The index advances modulo 2^`ring_len_code` after each descriptor and returns to 0 whenever `run` is low.
- R2: Word offsets within a descriptor: +0 holds the buffer address bits 15:0, +1 holds the status byte in bits 15:8 and address bits 23:16 in bits 7:0, +2 holds the negated byte length, and +3 holds the written-back status2 in bits 15:10 with a 10-bit reflectometry count in bits 9:0. The MAC sees `mac_buf_addr` = {word1[7:0], word0} and `mac_buf_len` = (0 - word2) taken over 12 bits.
- R3: Ownership is word1 bit 15 (status bit 7). A descriptor found not owned while no frame is open stops all descriptor reads until a `tx_demand` pulse arrives.
- R4: Status bit 1 (start) and bit 0 (end) appear on `mac_sop` and `mac_eop`. The request stays valid with a stable address and length until `mac_req_ready` is seen.
- R5: The engine never writes ownership as 1. A descriptor that is not the last of its frame gets its status byte written back with only the start/end marks and bit 5 kept, and that write happens only after the next descriptor has been found owned.
- R6: For the end-of-frame descriptor, the engine writes word3 first and then word1. `tx_done` pulses for one cycle, in the cycle after the word1 write. `mac_rsp_flags` bit 0 (deferred), bit 1 (one retry) and bit 2 (several retries) map to status bits 2, 3 and 4.
- R7: Status2 bits: bit 0 = retry failure (flag bit 3), bit 1 = carrier lost (flag bit 4), bit 2 = late collision (flag bit 5), bit 4 = underflow (flag bit 6), bit 5 = chain broken. Status bit 6 is set exactly when any status2 bit is set.
- R8: A retry failure or an underflow outcome raises `tx_off` once the final descriptor has been written back. While `tx_off` is high, no memory access and no MAC request take place, even after `tx_demand`.
- R9: If an open frame reaches a descriptor that is not owned, the last owned descriptor of that frame gets word3 = 16'h8000 and status with bit 6 set and ownership clear. `tx_off` rises and no `tx_done` is given.
- R10: A descriptor read returned with `mem_rd_err` gives one `mem_error` pulse in the next cycle, raises `tx_off`, and offers nothing to the MAC for that descriptor.
- R11: One cycle after `run` is low, the engine is idle with `tx_off` low. Raising `run` starts the walk at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Level enable; low stops the engine and clears the halt |
| tx_demand | input | 1 | One-cycle request to resume polling |
| ring_base | input | AW | Word address of descriptor 0 (low two bits ignored) |
| ring_len_code | input | 3 | Ring holds 2^code descriptors |
| mem_req | output | 1 | Descriptor memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after the read strobe |
| mem_rd_err | input | 1 | Fault flag returned with the read data |
| mac_req_valid | output | 1 | Buffer offered to the MAC |
| mac_req_ready | input | 1 | MAC accepts the offered buffer |
| mac_buf_addr | output | 24 | Buffer byte address |
| mac_buf_len | output | 12 | Buffer length in bytes |
| mac_sop | output | 1 | Buffer opens a frame |
| mac_eop | output | 1 | Buffer closes a frame |
| mac_rsp_valid | input | 1 | Frame outcome is present |
| mac_rsp_flags | input | 7 | Outcome flags (bit meanings in R6, R7) |
| mac_rsp_tdr | input | 10 | Reflectometry count for the frame |
| tx_done | output | 1 | Frame completion pulse |
| mem_error | output | 1 | Descriptor read fault pulse |
| tx_off | output | 1 | Transmitter parked after a fatal event |

## Verification
The hardest case to reach from the ports is the broken chain. It needs a frame already open on an owned descriptor that has been handed to the MAC, with the following descriptor left unowned, and this must happen after a restart so that the walk begins at index 0. The bench stops the engine, writes a start-only descriptor at index 0 while index 1 still holds a cleared descriptor from an earlier frame, and raises `run` again. A second hard case is the one-entry ring: it is reached by restarting with size code 0 and an unaligned base, and checking that a neighbouring owned descriptor is never touched.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int BAW = 24;

    // word offsets within one descriptor
    localparam int W_ALO  = 0;
    localparam int W_STAT = 1;
    localparam int W_SIZE = 2;
    localparam int W_TDR  = 3;

    // status byte bits
    localparam int ST_OWN  = 7;
    localparam int ST_ERR  = 6;
    localparam int ST_MORE = 4;
    localparam int ST_ONE  = 3;
    localparam int ST_DEF  = 2;

    // status2 bits
    localparam int S2_RTRY = 0;
    localparam int S2_LCAR = 1;
    localparam int S2_LCOL = 2;
    localparam int S2_UFLO = 4;
    localparam int S2_BUFF = 5;

    // MAC outcome flag bits
    localparam int FL_DEF   = 0;
    localparam int FL_ONCE  = 1;
    localparam int FL_MULTI = 2;
    localparam int FL_RTRY  = 3;
    localparam int FL_LCAR  = 4;
    localparam int FL_LCOL  = 5;
    localparam int FL_UFLO  = 6;

    // host bits carried through a writeback: start, end, reserved bit 5
    localparam logic [7:0] KEEP_MASK = 8'h23;

    typedef enum logic [3:0] {
        S_OFF,
        S_RD_STAT,
        S_CHK_STAT,
        S_GET_LO,
        S_GET_SIZE,
        S_WB_PREV,
        S_MAC,
        S_WAIT_RSP,
        S_WB_W3,
        S_WB_W1,
        S_BE_W3,
        S_BE_W1,
        S_WAIT_DEM,
        S_HALT
    } txr_state_e;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int AW = 24,
    parameter int CW = 3,
    localparam int IW = (1 << CW) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [AW-1:0] ring_base,
    input  logic [CW-1:0] len_code,
    output logic [AW-1:0] desc_base
);
    logic [IW-1:0] idx_d, idx_q;
    logic [IW-1:0] wrap_mask;

    always_comb begin
        wrap_mask = IW'((IW+1)'(1) << len_code) - IW'(1);
        idx_d     = idx_q;
        if (clear) begin
            idx_d = '0;
        end else if (step) begin
            idx_d = (idx_q + IW'(1)) & wrap_mask;
        end
        desc_base = (ring_base & ~AW'(3)) + AW'({idx_q, 2'b00});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end
endmodule

// File: rtl/txr_status_fmt.sv
module txr_status_fmt
    import txr_pkg::*;
(
    input  logic [7:0]  stat_in,
    input  logic [6:0]  flags,
    input  logic [9:0]  tdr,
    output logic [7:0]  done_stat,
    output logic [15:0] done_w3,
    output logic [7:0]  link_stat,
    output logic [7:0]  be_stat,
    output logic [15:0] be_w3,
    output logic        stop_tx
);
    logic [5:0] s2;

    always_comb begin
        s2          = '0;
        s2[S2_RTRY] = flags[FL_RTRY];
        s2[S2_LCAR] = flags[FL_LCAR];
        s2[S2_LCOL] = flags[FL_LCOL];
        s2[S2_UFLO] = flags[FL_UFLO];

        link_stat = stat_in & KEEP_MASK;

        done_stat          = link_stat;
        done_stat[ST_DEF]  = flags[FL_DEF];
        done_stat[ST_ONE]  = flags[FL_ONCE];
        done_stat[ST_MORE] = flags[FL_MULTI];
        done_stat[ST_ERR]  = |s2;
        done_w3            = {s2, tdr};

        be_stat         = link_stat;
        be_stat[ST_ERR] = 1'b1;
        be_w3           = 16'(1) << (10 + S2_BUFF);

        stop_tx = flags[FL_RTRY] | flags[FL_UFLO];
    end
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
    import txr_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           tx_demand,
    input  logic [AW-1:0]  cur_base,
    output logic           step,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [15:0]    mem_wdata,
    input  logic [15:0]    mem_rdata,
    input  logic           mem_rd_err,
    output logic           mac_req_valid,
    input  logic           mac_req_ready,
    output logic [BAW-1:0] mac_buf_addr,
    output logic [11:0]    mac_buf_len,
    output logic           mac_sop,
    output logic           mac_eop,
    input  logic           mac_rsp_valid,
    input  logic [6:0]     mac_rsp_flags,
    input  logic [9:0]     mac_rsp_tdr,
    output logic [7:0]     fmt_stat,
    output logic [6:0]     fmt_flags,
    output logic [9:0]     fmt_tdr,
    input  logic [7:0]     done_stat,
    input  logic [15:0]    done_w3,
    input  logic [7:0]     link_stat,
    input  logic [7:0]     be_stat,
    input  logic [15:0]    be_w3,
    input  logic           stop_tx,
    output logic           tx_done,
    output logic           mem_error,
    output logic           tx_off
);
    typedef struct packed {
        txr_state_e    state;
        logic [15:0]   cur_w1;
        logic [15:0]   cur_lo;
        logic [11:0]   cur_size;
        logic [AW-1:0] prev_base;
        logic [15:0]   prev_w1;
        logic          in_frame;
        logic [6:0]    flags;
        logic [9:0]    tdr;
        logic          done;
        logic          merr;
    } ctrl_t;

    ctrl_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.merr  = 1'b0;
        step      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_base;
        mem_wdata = '0;
        mac_req_valid = 1'b0;
        fmt_stat  = r_q.cur_w1[15:8];

        unique case (r_q.state)
            S_OFF: begin
                if (run) r_d.state = S_RD_STAT;
            end
            S_RD_STAT: begin
                mem_req   = 1'b1;
                mem_addr  = cur_base + AW'(W_STAT);
                r_d.state = S_CHK_STAT;
            end
            S_CHK_STAT: begin
                // address word is fetched speculatively
                mem_req  = 1'b1;
                mem_addr = cur_base + AW'(W_ALO);
                if (mem_rd_err) begin
                    r_d.merr  = 1'b1;
                    r_d.state = S_HALT;
                end else if (!mem_rdata[8+ST_OWN]) begin
                    r_d.state = r_q.in_frame ? S_BE_W3 : S_WAIT_DEM;
                end else begin
                    r_d.cur_w1 = mem_rdata;
                    r_d.state  = S_GET_LO;
                end
            end
            S_GET_LO: begin
                mem_req  = 1'b1;
                mem_addr = cur_base + AW'(W_SIZE);
                if (mem_rd_err) begin
                    r_d.merr  = 1'b1;
                    r_d.state = S_HALT;
                end else begin
                    r_d.cur_lo = mem_rdata;
                    r_d.state  = S_GET_SIZE;
                end
            end
            S_GET_SIZE: begin
                if (mem_rd_err) begin
                    r_d.merr  = 1'b1;
                    r_d.state = S_HALT;
                end else begin
                    r_d.cur_size = mem_rdata[11:0];
                    r_d.state    = r_q.in_frame ? S_WB_PREV : S_MAC;
                end
            end
            S_WB_PREV: begin
                fmt_stat  = r_q.prev_w1[15:8];
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.prev_base + AW'(W_STAT);
                mem_wdata = {link_stat, r_q.prev_w1[7:0]};
                r_d.state = S_MAC;
            end
            S_MAC: begin
                mac_req_valid = 1'b1;
                if (mac_req_ready) begin
                    if (r_q.cur_w1[8]) begin
                        r_d.in_frame = 1'b0;
                        r_d.state    = S_WAIT_RSP;
                    end else begin
                        r_d.prev_base = cur_base;
                        r_d.prev_w1   = r_q.cur_w1;
                        r_d.in_frame  = 1'b1;
                        step          = 1'b1;
                        r_d.state     = S_RD_STAT;
                    end
                end
            end
            S_WAIT_RSP: begin
                if (mac_rsp_valid) begin
                    r_d.flags = mac_rsp_flags;
                    r_d.tdr   = mac_rsp_tdr;
                    r_d.state = S_WB_W3;
                end
            end
            S_WB_W3: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_base + AW'(W_TDR);
                mem_wdata = done_w3;
                r_d.state = S_WB_W1;
            end
            S_WB_W1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_base + AW'(W_STAT);
                mem_wdata = {done_stat, r_q.cur_w1[7:0]};
                r_d.done  = 1'b1;
                step      = 1'b1;
                r_d.state = stop_tx ? S_HALT : S_RD_STAT;
            end
            S_BE_W3: begin
                fmt_stat  = r_q.prev_w1[15:8];
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.prev_base + AW'(W_TDR);
                mem_wdata = be_w3;
                r_d.state = S_BE_W1;
            end
            S_BE_W1: begin
                fmt_stat     = r_q.prev_w1[15:8];
                mem_req      = 1'b1;
                mem_we       = 1'b1;
                mem_addr     = r_q.prev_base + AW'(W_STAT);
                mem_wdata    = {be_stat, r_q.prev_w1[7:0]};
                r_d.in_frame = 1'b0;
                r_d.state    = S_HALT;
            end
            S_WAIT_DEM: begin
                if (tx_demand) r_d.state = S_RD_STAT;
            end
            S_HALT: begin
                r_d.state = S_HALT;
            end
            default: r_d.state = S_OFF;
        endcase

        if (!run) begin
            r_d.state    = S_OFF;
            r_d.in_frame = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_OFF, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign fmt_flags    = r_q.flags;
    assign fmt_tdr      = r_q.tdr;
    assign mac_buf_addr = {r_q.cur_w1[7:0], r_q.cur_lo};
    assign mac_buf_len  = 12'd0 - r_q.cur_size;
    assign mac_sop      = r_q.cur_w1[9];
    assign mac_eop      = r_q.cur_w1[8];
    assign tx_done      = r_q.done;
    assign mem_error    = r_q.merr;
    assign tx_off       = (r_q.state == S_HALT);
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import txr_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           tx_demand,
    input  logic [AW-1:0]  ring_base,
    input  logic [2:0]     ring_len_code,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [15:0]    mem_wdata,
    input  logic [15:0]    mem_rdata,
    input  logic           mem_rd_err,
    output logic           mac_req_valid,
    input  logic           mac_req_ready,
    output logic [BAW-1:0] mac_buf_addr,
    output logic [11:0]    mac_buf_len,
    output logic           mac_sop,
    output logic           mac_eop,
    input  logic           mac_rsp_valid,
    input  logic [6:0]     mac_rsp_flags,
    input  logic [9:0]     mac_rsp_tdr,
    output logic           tx_done,
    output logic           mem_error,
    output logic           tx_off
);
    logic [AW-1:0] cur_base;
    logic          step;
    logic [7:0]    fmt_stat;
    logic [6:0]    fmt_flags;
    logic [9:0]    fmt_tdr;
    logic [7:0]    done_stat, link_stat, be_stat;
    logic [15:0]   done_w3, be_w3;
    logic          stop_tx;

    txr_ring_ptr #(.AW(AW), .CW(3)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!run),
        .step      (step),
        .ring_base (ring_base),
        .len_code  (ring_len_code),
        .desc_base (cur_base)
    );

    txr_status_fmt u_fmt (
        .stat_in   (fmt_stat),
        .flags     (fmt_flags),
        .tdr       (fmt_tdr),
        .done_stat (done_stat),
        .done_w3   (done_w3),
        .link_stat (link_stat),
        .be_stat   (be_stat),
        .be_w3     (be_w3),
        .stop_tx   (stop_tx)
    );

    txr_ctrl #(.AW(AW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .tx_demand     (tx_demand),
        .cur_base      (cur_base),
        .step          (step),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_rd_err    (mem_rd_err),
        .mac_req_valid (mac_req_valid),
        .mac_req_ready (mac_req_ready),
        .mac_buf_addr  (mac_buf_addr),
        .mac_buf_len   (mac_buf_len),
        .mac_sop       (mac_sop),
        .mac_eop       (mac_eop),
        .mac_rsp_valid (mac_rsp_valid),
        .mac_rsp_flags (mac_rsp_flags),
        .mac_rsp_tdr   (mac_rsp_tdr),
        .fmt_stat      (fmt_stat),
        .fmt_flags     (fmt_flags),
        .fmt_tdr       (fmt_tdr),
        .done_stat     (done_stat),
        .done_w3       (done_w3),
        .link_stat     (link_stat),
        .be_stat       (be_stat),
        .be_w3         (be_w3),
        .stop_tx       (stop_tx),
        .tx_done       (tx_done),
        .mem_error     (mem_error),
        .tx_off        (tx_off)
    );
endmodule

// File: rtl/txr_ring_chk.sv
module txr_ring_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic        mem_req,
    input logic        mem_we,
    input logic [1:0]  mem_addr_lo,
    input logic        wdata_own,
    input logic        mem_rd_err,
    input logic        mac_req_valid,
    input logic        mac_req_ready,
    input logic [23:0] mac_buf_addr,
    input logic [11:0] mac_buf_len,
    input logic        tx_done,
    input logic        mem_error,
    input logic        tx_off
);
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mac_req_valid && !mac_req_ready |=>
            mac_req_valid && $stable(mac_buf_addr) && $stable(mac_buf_len));

    a_r5_own_never_set: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_addr_lo == 2'd1 |-> !wdata_own);

    a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(mem_req && mem_we));

    a_r8_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_off |-> !mem_req && !mac_req_valid);

    a_r10_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
        mem_error |-> $past(mem_rd_err));

    a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && mem_error));

    a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mem_req && !mac_req_valid && !tx_off);
endmodule

bind tx_ring_engine txr_ring_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr_lo   (mem_addr[1:0]),
    .wdata_own     (mem_wdata[15]),
    .mem_rd_err    (mem_rd_err),
    .mac_req_valid (mac_req_valid),
    .mac_req_ready (mac_req_ready),
    .mac_buf_addr  (mac_buf_addr),
    .mac_buf_len   (mac_buf_len),
    .tx_done       (tx_done),
    .mem_error     (mem_error),
    .tx_off        (tx_off)
);

// File: tb/tx_ring_engine_tb_top.sv
module tx_ring_engine_tb_top;
    localparam int AW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic tx_demand = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic [2:0] ring_len_code = 3'd0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic mem_rd_err = 1'b0;
    logic mac_req_valid;
    logic mac_req_ready = 1'b0;
    logic [23:0] mac_buf_addr;
    logic [11:0] mac_buf_len;
    logic mac_sop, mac_eop;
    logic mac_rsp_valid = 1'b0;
    logic [6:0] mac_rsp_flags = '0;
    logic [9:0] mac_rsp_tdr = '0;
    logic tx_done, mem_error, tx_off;

    always #2 clk = ~clk;

    tx_ring_engine #(.AW(AW)) dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;
    int acc_cnt = 0;
    int done_cnt = 0;
    int merr_cnt = 0;
    int err_addr = -1;
    int rdy_cnt = 0;
    int rsp_cd = 0;
    bit fin = 0;
    logic [16:0] rsp_hold;
    logic [15:0] mem [0:1023];
    logic [37:0] exp_q [$];
    logic [16:0] rsp_q [$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // descriptor memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rd_err <= 1'b0;
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[9:0]] <= mem_wdata;
            end else begin
                mem_rdata  <= mem[mem_addr[9:0]];
                mem_rd_err <= (int'(mem_addr[9:0]) == err_addr);
            end
        end
    end

    // MAC model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            rdy_cnt++;
            mac_req_ready = (rdy_cnt % 3 != 1);
            mac_rsp_valid = 1'b0;
            if (rsp_cd > 0) begin
                rsp_cd--;
                if (rsp_cd == 0) begin
                    mac_rsp_valid = 1'b1;
                    {mac_rsp_flags, mac_rsp_tdr} = rsp_hold;
                end
            end
            if (mac_req_valid && mac_req_ready) begin
                acc_cnt++;
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected MAC request", {26'd0, mac_buf_addr, mac_buf_len, mac_sop, mac_eop}, 64'd0);
                end else begin
                    chk("R2/R4 MAC request fields", {mac_buf_addr, mac_buf_len, mac_sop, mac_eop}, exp_q.pop_front());
                end
                if (mac_eop) begin
                    rsp_hold = (rsp_q.size() > 0) ? rsp_q.pop_front() : 17'd0;
                    rsp_cd = 3;
                end
            end
            if (tx_done) done_cnt++;
            if (mem_error) merr_cnt++;
        end
    end

    task automatic put_desc(input int base, input int idx, input logic [23:0] baddr,
                            input int len, input bit sop, input bit eop, input bit own, input bit push);
        int a = base + idx * 4;
        mem[a]     = baddr[15:0];
        mem[a + 1] = {own, 5'b0, sop, eop, baddr[23:16]};
        mem[a + 2] = 16'h0 - 16'(len);
        mem[a + 3] = 16'h0;
        if (push) exp_q.push_back({baddr, 12'(len), sop, eop});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic demand();
        @(negedge clk);
        tx_demand = 1'b1;
        @(negedge clk);
        tx_demand = 1'b0;
    endtask

    task automatic wait_done(input int target, input string tag);
        int n = 0;
        while (done_cnt < target && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, 64'(done_cnt), 64'(target));
        ticks(2);
    endtask

    task automatic wait_off(input string tag);
        int n = 0;
        while (!tx_off && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, 64'(tx_off), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int acc0, d0, m0;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
        ring_base = 24'h100;
        ring_len_code = 3'd2;
        ticks(3);
        rst_n = 1'b1;
        ticks(2);
        chk("R11 reset tx_done", 64'(tx_done), 0);
        chk("R11 reset tx_off", 64'(tx_off), 0);
        chk("R11 reset mac_req_valid", 64'(mac_req_valid), 0);
        chk("R11 reset mem_req", 64'(mem_req), 0);

        // single-buffer frame at index 0, deferred outcome
        put_desc(32'h100, 0, 24'h12_3456, 64, 1, 1, 1, 1);
        rsp_q.push_back({7'b0000001, 10'h155});
        run = 1'b1;
        wait_done(1, "R6 first frame done");
        chk("R6 final status word", 64'(mem[16'h101]), 64'h0712);
        chk("R2 tdr word", 64'(mem[16'h103]), 64'h0155);

        // two-buffer chain at indexes 1,2: one retry plus carrier loss
        put_desc(32'h100, 1, 24'h00_0200, 100, 1, 0, 1, 1);
        put_desc(32'h100, 2, 24'h00_0400, 20, 0, 1, 1, 1);
        rsp_q.push_back({7'b0010010, 10'h003});
        demand();
        wait_done(2, "R3 demand resumes chain");
        chk("R5 linked descriptor released", 64'(mem[16'h105]), 64'h0200);
        chk("R7 chain final status", 64'(mem[16'h109]), 64'h4900);
        chk("R7 chain status2", 64'(mem[16'h10B]), 64'h0803);

        // wrap from index 3 to index 0
        put_desc(32'h100, 3, 24'hAB_0010, 300, 1, 1, 1, 1);
        put_desc(32'h100, 0, 24'hCD_0020, 1500, 1, 1, 1, 1);
        rsp_q.push_back({7'b0000100, 10'h000});
        rsp_q.push_back({7'b0000100, 10'h000});
        demand();
        wait_done(4, "R1 wrap frames done");
        chk("R1 index 3 status", 64'(mem[16'h10D]), 64'h13AB);
        chk("R1 wrapped index 0 status", 64'(mem[16'h101]), 64'h13CD);

        // polling stopped: owned descriptor stays untouched without demand
        acc0 = acc_cnt;
        put_desc(32'h100, 1, 24'h00_0800, 64, 1, 1, 1, 1);
        ticks(60);
        chk("R3 no poll without demand", 64'(acc_cnt), 64'(acc0));
        chk("R3 descriptor still owned", 64'(mem[16'h105]), 64'h8300);
        rsp_q.push_back({7'b0000000, 10'h000});
        demand();
        wait_done(5, "R3 demand processes frame");
        chk("R6 plain completion status", 64'(mem[16'h105]), 64'h0300);

        // underflow parks the transmitter
        put_desc(32'h100, 2, 24'h00_0900, 64, 1, 1, 1, 1);
        rsp_q.push_back({7'b1000000, 10'h000});
        demand();
        wait_done(6, "R8 underflow frame done");
        chk("R7 underflow status", 64'(mem[16'h109]), 64'h4300);
        chk("R7 underflow status2", 64'(mem[16'h10B]), 64'h4000);
        chk("R8 tx_off after underflow", 64'(tx_off), 1);
        acc0 = acc_cnt;
        put_desc(32'h100, 3, 24'h00_0A00, 64, 1, 1, 1, 0);
        demand();
        ticks(40);
        chk("R8 parked ignores demand", 64'(acc_cnt), 64'(acc0));
        chk("R8 parked leaves descriptor", 64'(mem[16'h10D]), 64'h8300);
        mem[16'h10D] = 16'h0300;

        // restart, then broken chain at index 0
        @(negedge clk);
        run = 1'b0;
        ticks(2);
        chk("R11 stop clears tx_off", 64'(tx_off), 0);
        d0 = done_cnt;
        put_desc(32'h100, 0, 24'h00_0C00, 120, 1, 0, 1, 1);
        run = 1'b1;
        wait_off("R9 broken chain parks");
        ticks(2);
        chk("R9 broken chain status", 64'(mem[16'h101]), 64'h4200);
        chk("R9 broken chain status2", 64'(mem[16'h103]), 64'h8000);
        chk("R9 no done pulse", 64'(done_cnt), 64'(d0));

        // memory fault on the address word
        @(negedge clk);
        run = 1'b0;
        ticks(2);
        acc0 = acc_cnt;
        m0 = merr_cnt;
        put_desc(32'h100, 0, 24'h00_0D00, 64, 1, 1, 1, 0);
        err_addr = 32'h100;
        run = 1'b1;
        wait_off("R10 fault parks");
        ticks(2);
        chk("R10 one mem_error pulse", 64'(merr_cnt), 64'(m0 + 1));
        chk("R10 nothing offered", 64'(acc_cnt), 64'(acc0));
        chk("R10 descriptor still owned", 64'(mem[16'h101][15]), 1);
        err_addr = -1;

        // one-entry ring at an unaligned base
        @(negedge clk);
        run = 1'b0;
        ring_base = 24'h203;
        ring_len_code = 3'd0;
        ticks(2);
        d0 = done_cnt;
        put_desc(32'h200, 0, 24'h00_0E00, 64, 1, 1, 1, 1);
        put_desc(32'h200, 1, 24'h00_0F00, 64, 1, 1, 1, 0);
        rsp_q.push_back({7'b0000000, 10'h000});
        run = 1'b1;
        wait_done(d0 + 1, "R1 single-entry first frame");
        chk("R1 aligned base status", 64'(mem[16'h201]), 64'h0300);
        put_desc(32'h200, 0, 24'h00_0E40, 64, 1, 1, 1, 1);
        rsp_q.push_back({7'b0000000, 10'h000});
        demand();
        wait_done(d0 + 2, "R1 single-entry repeat");
        ticks(10);
        chk("R1 neighbour never touched", 64'(mem[16'h205]), 64'h8300);
        chk("R4 all expected requests seen", 64'(exp_q.size()), 0);

        fin = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule